// File: doc/BRIEF.md
# Chained-Descriptor Endpoint DMA Channel

This block is one DMA channel that moves a buffer between system memory and the packet banks of a USB device endpoint. Software places transfer descriptors in memory. It then presents the address of the first one and pulses a load request. The channel reads the three descriptor words over a simple read port and moves the buffer one 32-bit word at a time over a valid/ready data port. When the buffer ends it writes a status snapshot. If the descriptor asks for it, the channel then follows the descriptor's next pointer and repeats the sequence.

Bank handshakes with the endpoint are automatic. The channel tracks how many bytes have gone into or out of the current bank. When a full maximum-size packet has passed, it can mark an IN bank ready or release an OUT bank. At buffer end it can also validate a short final packet. A transfer in progress can be stopped in two ways. Software can clear the channel enable, in which case the word in flight completes first. An endpoint interrupt can abort it at once if the halt-on-interrupt option is set. In either case the remaining byte count is kept in the status.

Top module: `ep_dma_chain`

## Requirements
- R1: A fetch reads exactly three words at addresses B, B+4 and B+8, where B is the descriptor address with its two low bits forced to zero. The three words are taken in that order as the next pointer, the buffer address and the control word.
- R2: Control word layout: bits 15:0 byte count, bit 16 load-next, bit 17 channel-enable, bit 18 end-of-buffer interrupt enable, bit 19 end-of-buffer validate enable. Higher bits are ignored.
- R3: Data words go out at the buffer address and then at +4 per word. Each word carries min(4, remaining) bytes on `xfer_nbytes`, until the remaining count is 0. A count of 0 moves no data.
- R4: At buffer end with load-next=1, the next fetch uses the next pointer taken from that descriptor. With load-next=0 the channel goes idle (`busy`=0).
- R5: After reset the status reads count 0, end 0 and halt 0. A completed buffer leaves count 0, end 1 and halt 0.
- R6: `buf_irq` pulses for one cycle at each buffer end whose interrupt enable is set, zero-length buffers included. It never pulses for a halted buffer.
- R7: With `auto_valid`=1, every time the bank fill reaches MPS bytes, the channel pulses `bank_set` (`dir_in`=1) or `bank_clr` (`dir_in`=0) and the fill restarts at 0. With `auto_valid`=0 there is no pulse and the fill holds at MPS.
- R8: At buffer end with validate enable set and a nonzero fill, the channel gives one bank pulse of the current direction and the fill restarts at 0. With zero fill there is no pulse.
- R9: A descriptor with channel-enable=0 moves no data. The channel stops with status count equal to the descriptor count, halt 1 and end 0.
- R10: `sw_disable` during a run lets the word accepted in that cycle complete. The channel then stops with the remaining count, halt 1, no interrupt and no end validation.
- R11: While `irq_halt_en`=1, an `ep_irq` during a run blocks the word of that cycle and stops the channel with the remaining count and halt 1. While `irq_halt_en`=0, `ep_irq` has no effect.
- R12: `sw_load` starts a fetch from `sw_nxt` while the channel is idle or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_load | input | 1 | Pulse: load the descriptor at `sw_nxt` |
| sw_nxt | input | AW | First descriptor address |
| sw_disable | input | 1 | Pulse: clear channel enable |
| irq_halt_en | input | 1 | Endpoint interrupt aborts the transfer |
| ep_irq | input | 1 | Enabled endpoint interrupt |
| dir_in | input | 1 | 1 = IN (to host), 0 = OUT |
| auto_valid | input | 1 | Automatic bank validation |
| dsc_rd | output | 1 | Descriptor read request |
| dsc_addr | output | AW | Descriptor word address |
| dsc_gnt | input | 1 | Read accepted, data valid |
| dsc_rdata | input | 32 | Descriptor word |
| xfer_vld | output | 1 | Data word offered |
| xfer_addr | output | AW | Buffer word address |
| xfer_nbytes | output | 3 | Valid bytes in the word |
| xfer_rdy | input | 1 | Endpoint side accepts word |
| bank_set | output | 1 | Pulse: IN bank ready |
| bank_clr | output | 1 | Pulse: OUT bank released |
| buf_irq | output | 1 | Pulse: buffer-end interrupt |
| sts_cnt | output | 16 | Remaining bytes at last status write |
| sts_end | output | 1 | Last buffer ran to its end |
| sts_halt | output | 1 | Channel was stopped early |
| busy | output | 1 | Fetching or transferring |

## Verification
The bench builds the channel with MPS=8, so two full words already fill a bank. Every buffer then crosses several bank boundaries, and the end-of-buffer validation sees both empty and partly filled banks. Buffers of 13 and 12 bytes bring an odd tail word and the saturated fill without auto-valid within reach. A 40-byte buffer leaves room to disable or abort after a chosen number of words.

// File: rtl/ep_dma_chain.sv
module ep_dma_chain #(
  parameter int AW  = 32,
  parameter int MPS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_load,
  input  logic [AW-1:0] sw_nxt,
  input  logic          sw_disable,
  input  logic          irq_halt_en,
  input  logic          ep_irq,
  input  logic          dir_in,
  input  logic          auto_valid,
  output logic          dsc_rd,
  output logic [AW-1:0] dsc_addr,
  input  logic          dsc_gnt,
  input  logic [31:0]   dsc_rdata,
  output logic          xfer_vld,
  output logic [AW-1:0] xfer_addr,
  output logic [2:0]    xfer_nbytes,
  input  logic          xfer_rdy,
  output logic          bank_set,
  output logic          bank_clr,
  output logic          buf_irq,
  output logic [15:0]   sts_cnt,
  output logic          sts_end,
  output logic          sts_halt,
  output logic          busy
);
  localparam int BW   = $clog2(MPS + 5);
  localparam int LD_B = 16;
  localparam int EN_B = 17;
  localparam int IE_B = 18;
  localparam int VE_B = 19;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RUN, S_BEND, S_SWB, S_STOP} st_t;

  st_t           st;
  logic [1:0]    widx;
  logic [AW-1:0] base_q, nxt_q, buf_q;
  logic [15:0]   cnt_q;
  logic          ld_q, en_q, ie_q, ve_q;
  logic [BW-1:0] bank_q;
  logic          set_q, clr_q, irq_q;

  logic [2:0]    nb;
  logic [BW-1:0] bank_sum;
  logic          abort, fire, last, start;

  assign nb          = (cnt_q < 16'd4) ? cnt_q[2:0] : 3'd4;
  assign bank_sum    = bank_q + BW'(nb);
  assign last        = (cnt_q == {13'd0, nb});
  assign abort       = irq_halt_en & ep_irq;
  assign start       = sw_load & (st == S_IDLE || st == S_STOP);
  assign dsc_rd      = (st == S_FETCH);
  assign dsc_addr    = base_q + AW'({widx, 2'b00});
  assign xfer_vld    = (st == S_RUN) & en_q & ~abort;
  assign fire        = xfer_vld & xfer_rdy;
  assign xfer_addr   = buf_q;
  assign xfer_nbytes = nb;
  assign bank_set    = set_q;
  assign bank_clr    = clr_q;
  assign buf_irq     = irq_q;
  assign busy        = (st != S_IDLE) && (st != S_STOP);

  wire unused_bits = ^{dsc_rdata[31:20], nxt_q[1:0], sw_nxt[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  widx <= '0;
      base_q <= '0;  nxt_q <= '0;  buf_q <= '0;  cnt_q <= '0;
      ld_q <= 1'b0;  en_q <= 1'b0; ie_q <= 1'b0; ve_q <= 1'b0;
      bank_q <= '0;  set_q <= 1'b0; clr_q <= 1'b0; irq_q <= 1'b0;
      sts_cnt <= '0; sts_end <= 1'b0; sts_halt <= 1'b0;
    end else begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
      irq_q <= 1'b0;
      if (sw_disable) en_q <= 1'b0;
      case (st)
        S_IDLE, S_STOP: if (start) begin
          base_q <= {sw_nxt[AW-1:2], 2'b00};
          widx   <= '0;
          st     <= S_FETCH;
        end
        S_FETCH: if (dsc_gnt) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: nxt_q <= dsc_rdata[AW-1:0];
            2'd1: buf_q <= dsc_rdata[AW-1:0];
            default: begin
              widx  <= '0;
              cnt_q <= dsc_rdata[15:0];
              ld_q  <= dsc_rdata[LD_B];
              en_q  <= dsc_rdata[EN_B];
              ie_q  <= dsc_rdata[IE_B];
              ve_q  <= dsc_rdata[VE_B];
              if (!dsc_rdata[EN_B]) begin
                st       <= S_STOP;
                sts_cnt  <= dsc_rdata[15:0];
                sts_end  <= 1'b0;
                sts_halt <= 1'b1;
              end else if (dsc_rdata[15:0] == 16'd0) st <= S_BEND;
              else st <= S_RUN;
            end
          endcase
        end
        S_RUN: begin
          if (abort || !en_q) begin
            st       <= S_STOP;
            sts_cnt  <= cnt_q;
            sts_end  <= 1'b0;
            sts_halt <= 1'b1;
          end else if (fire) begin
            cnt_q <= cnt_q - {13'd0, nb};
            buf_q <= buf_q + AW'(4);
            if (bank_sum >= BW'(MPS)) begin
              if (auto_valid) begin
                set_q  <= dir_in;
                clr_q  <= ~dir_in;
                bank_q <= '0;
              end else bank_q <= BW'(MPS);
            end else bank_q <= bank_sum;
            if (last) st <= S_BEND;
          end
        end
        S_BEND: begin
          irq_q <= ie_q;
          if (ve_q && bank_q != '0) begin
            set_q  <= dir_in;
            clr_q  <= ~dir_in;
            bank_q <= '0;
          end
          st <= S_SWB;
        end
        S_SWB: begin
          sts_cnt  <= cnt_q;
          sts_end  <= 1'b1;
          sts_halt <= 1'b0;
          if (ld_q) begin
            base_q <= {nxt_q[AW-1:2], 2'b00};
            widx   <= '0;
            st     <= S_FETCH;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ep_dma_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dsc_rd,
  input logic [AW-1:0] dsc_addr,
  input logic          xfer_vld,
  input logic          xfer_rdy,
  input logic [AW-1:0] xfer_addr,
  input logic          busy,
  input logic          sw_load,
  input logic [15:0]   sts_cnt,
  input logic          sts_end,
  input logic          sts_halt,
  input logic          buf_irq,
  input logic          bank_set,
  input logic          bank_clr
);
  // R1
  aligned_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_rd |-> (dsc_addr[1:0] == 2'b00 && busy));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && xfer_rdy) |=> (xfer_addr == $past(xfer_addr) + AW'(4)));
  // R5
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !sts_halt) |-> (sts_cnt == 16'd0 && sts_end));
  // R6
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |=> (sts_end && !sts_halt));
  // R7
  bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_set && bank_clr));
  // R12
  quiet_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sw_load) |=> ($stable(sts_cnt) && !busy));
endmodule

bind ep_dma_chain ep_dma_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsc_rd(dsc_rd), .dsc_addr(dsc_addr),
  .xfer_vld(xfer_vld), .xfer_rdy(xfer_rdy), .xfer_addr(xfer_addr),
  .busy(busy), .sw_load(sw_load), .sts_cnt(sts_cnt), .sts_end(sts_end),
  .sts_halt(sts_halt), .buf_irq(buf_irq), .bank_set(bank_set),
  .bank_clr(bank_clr)
);

// File: tb/ep_dma_chain_tb.sv
module ep_dma_chain_tb;
  localparam int AW  = 32;
  localparam int MPS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_load = 1'b0, sw_disable = 1'b0, irq_halt_en = 1'b0, ep_irq = 1'b0;
  logic dir_in = 1'b1, auto_valid = 1'b1;
  logic [AW-1:0] sw_nxt = '0;
  logic dsc_rd, dsc_gnt, xfer_vld, xfer_rdy, bank_set, bank_clr, buf_irq;
  logic sts_end, sts_halt, busy;
  logic [AW-1:0] dsc_addr, xfer_addr;
  logic [31:0] dsc_rdata;
  logic [2:0] xfer_nbytes;
  logic [15:0] sts_cnt;
  logic rdy_auto = 1'b1, rdy_man = 1'b0;
  logic [7:0] cyc = '0;
  logic [31:0] mem [0:255];

  int checks = 0, errors = 0;
  int fq[$], wa[$], wn[$], bq[$];
  int irq_exp = 0, mbank = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 8'd1;
  assign dsc_gnt   = (cyc[1:0] != 2'd1);
  assign xfer_rdy  = rdy_auto ? (cyc % 3 != 0) : rdy_man;
  assign dsc_rdata = mem[dsc_addr[9:2]];

  ep_dma_chain #(.AW(AW), .MPS(MPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .sw_nxt(sw_nxt),
    .sw_disable(sw_disable), .irq_halt_en(irq_halt_en), .ep_irq(ep_irq),
    .dir_in(dir_in), .auto_valid(auto_valid), .dsc_rd(dsc_rd),
    .dsc_addr(dsc_addr), .dsc_gnt(dsc_gnt), .dsc_rdata(dsc_rdata),
    .xfer_vld(xfer_vld), .xfer_addr(xfer_addr), .xfer_nbytes(xfer_nbytes),
    .xfer_rdy(xfer_rdy), .bank_set(bank_set), .bank_clr(bank_clr),
    .buf_irq(buf_irq), .sts_cnt(sts_cnt), .sts_end(sts_end),
    .sts_halt(sts_halt), .busy(busy)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put_desc(int at, int nxt, int bufa, int cnt, bit ld, bit en, bit ie, bit ve);
    mem[at >> 2]       = nxt;
    mem[(at >> 2) + 1] = bufa;
    mem[(at >> 2) + 2] = cnt | (ld << 16) | (en << 17) | (ie << 18) | (ve << 19) | 32'hA5F0_0000;
  endtask

  task automatic exp_word(int a, int n);
    wa.push_back(a);
    wn.push_back(n);
    mbank += n;
    if (mbank >= MPS) begin
      if (auto_valid) begin
        bq.push_back(dir_in);
        mbank = 0;
      end else mbank = MPS;
    end
  endtask

  task automatic exp_fetch(int at);
    fq.push_back(at);
    fq.push_back(at + 4);
    fq.push_back(at + 8);
  endtask

  task automatic exp_buf(int at, int bufa, int cnt, bit ie, bit ve);
    int rem = cnt;
    int a = bufa;
    exp_fetch(at);
    while (rem > 0) begin
      exp_word(a, rem < 4 ? rem : 4);
      rem -= (rem < 4 ? rem : 4);
      a += 4;
    end
    if (ve && mbank != 0) begin
      bq.push_back(dir_in);
      mbank = 0;
    end
    if (ie) irq_exp++;
  endtask

  task automatic kick(int addr);
    @(negedge clk);
    sw_nxt  = addr;
    sw_load = 1'b1;
    @(negedge clk);
    sw_load = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_done(string r, int cnt, int e, int h);
    chk({r, " status count"}, sts_cnt, cnt);
    chk({r, " status end"}, sts_end, e);
    chk({r, " status halt"}, sts_halt, h);
    chk({r, " queues drained"}, fq.size() + wa.size() + bq.size() + irq_exp, 0);
  endtask

  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (dsc_rd && dsc_gnt) begin
        if (fq.size() == 0) chk("R1 unexpected fetch", dsc_addr, -1);
        else chk("R1 fetch address", dsc_addr, fq.pop_front());
      end
      if (xfer_vld && xfer_rdy) begin
        if (wa.size() == 0) chk("R3 unexpected word", xfer_addr, -1);
        else begin
          chk("R3 word address", xfer_addr, wa.pop_front());
          chk("R3 word bytes", xfer_nbytes, wn.pop_front());
        end
      end
      if (bank_set || bank_clr) begin
        chk("R7 R8 single bank pulse", bank_set & bank_clr, 0);
        if (bq.size() == 0) chk("R7 R8 unexpected bank pulse", bank_set, -1);
        else chk("R7 R8 bank pulse direction", bank_set, bq.pop_front());
      end
      if (buf_irq) begin
        if (irq_exp == 0) chk("R6 unexpected interrupt", 1, 0);
        else irq_exp--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #3;
    chk("R5 reset busy", busy, 0);
    chk("R5 reset fetch", dsc_rd, 0);
    chk("R5 reset word", xfer_vld, 0);
    chk("R5 reset status", {sts_cnt, sts_end, sts_halt}, 0);
    chk("R5 reset pulses", {bank_set, bank_clr, buf_irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R4 R7 R8 R6 R12: two-link chain, misaligned start, IN with auto-valid
    dir_in = 1'b1; auto_valid = 1'b1;
    put_desc(32'h40, 32'h80, 32'h400, 13, 1, 1, 1, 1);
    put_desc(32'h80, 32'h0, 32'h500, 8, 0, 1, 0, 1);
    exp_buf(32'h40, 32'h400, 13, 1, 1);
    exp_buf(32'h80, 32'h500, 8, 0, 1);
    kick(32'h43);
    wait_idle();
    chk_done("R4 R5 chain", 0, 1, 0);

    // R7 R8: OUT without auto-valid, fill saturates then end validation releases
    dir_in = 1'b0; auto_valid = 1'b0;
    put_desc(32'hC0, 32'h0, 32'h600, 12, 0, 1, 1, 1);
    exp_buf(32'hC0, 32'h600, 12, 1, 1);
    kick(32'hC0);
    wait_idle();
    chk_done("R7 saturate", 0, 1, 0);

    // R3 R6 R8: zero-length buffer, interrupt but no bank pulse
    auto_valid = 1'b1;
    put_desc(32'h20, 32'h0, 32'h700, 0, 0, 1, 1, 1);
    exp_buf(32'h20, 32'h700, 0, 1, 1);
    kick(32'h20);
    wait_idle();
    chk_done("R3 zero length", 0, 1, 0);

    // R9: descriptor with channel-enable clear
    put_desc(32'hE0, 32'h0, 32'h800, 20, 1, 0, 1, 1);
    exp_fetch(32'hE0);
    kick(32'hE0);
    wait_idle();
    chk_done("R9 disabled descriptor", 20, 0, 1);

    // R10: software disable after three words
    dir_in = 1'b1;
    rdy_auto = 1'b0;
    put_desc(32'h100, 32'h0, 32'h900, 40, 0, 1, 1, 1);
    exp_fetch(32'h100);
    for (int k = 0; k < 3; k++) exp_word(32'h900 + 4 * k, 4);
    kick(32'h100);
    while (!xfer_vld) @(negedge clk);
    for (int k = 1; k <= 3; k++) begin
      rdy_man = 1'b1;
      sw_disable = (k == 3);
      @(negedge clk);
    end
    rdy_man = 1'b0;
    sw_disable = 1'b0;
    wait_idle();
    chk_done("R10 disable", 28, 0, 1);

    // R11 R12: restart from stopped, abort by endpoint interrupt on fourth cycle
    irq_halt_en = 1'b1;
    put_desc(32'h140, 32'h0, 32'hA00, 40, 0, 1, 1, 1);
    exp_fetch(32'h140);
    for (int k = 0; k < 3; k++) exp_word(32'hA00 + 4 * k, 4);
    kick(32'h140);
    while (!xfer_vld) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      rdy_man = 1'b1;
      ep_irq = (k == 4);
      @(negedge clk);
    end
    rdy_man = 1'b0;
    ep_irq = 1'b0;
    wait_idle();
    chk_done("R11 abort", 28, 0, 1);

    // R11: interrupt ignored while halt option is off
    irq_halt_en = 1'b0;
    ep_irq = 1'b1;
    rdy_auto = 1'b1;
    dir_in = 1'b0;
    put_desc(32'h180, 32'h0, 32'hB00, 10, 0, 1, 1, 1);
    exp_buf(32'h180, 32'hB00, 10, 1, 1);
    kick(32'h180);
    wait_idle();
    ep_irq = 1'b0;
    chk_done("R11 irq ignored", 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule